// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM of 128 K locations. The host presents one read or write at a time on a valid/ready handshake. The controller then sequences the active-low select, output-gate and write strobes, holds the 17-bit address and drives the 8-bit data bus. The bus is modelled as separate outgoing data, incoming data and a drive-enable. Every interval the memory needs is counted in clock cycles from a parameter: address setup, read access, write pulse, data setup, data hold and strobe recovery.

A supply-good input stands in for a voltage monitor. While it is low the memory is kept deselected and no new write can start. A write that was already accepted still finishes with its full pulse and hold. A read that is under way is abandoned at once and answered with an error. Requests that arrive while the supply is bad are answered with an error and are never executed. Each request ends with exactly one single-cycle response pulse, which carries the read byte for a successful read.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and after reset, the select, output-gate and write strobes are high, the data bus is not driven, no response is pending and `req_ready` is high.
- R2: A read lowers the select strobe for T_ADDR_SETUP cycles with the output gate high, then lowers the output gate for T_ACCESS cycles. It captures `mem_dq_in` at the last of those cycles and presents it on `resp_rdata` with `resp_valid` exactly T_ADDR_SETUP + T_ACCESS cycles after the accepting clock edge.
- R3: During a write the write strobe is low for exactly W = max(T_WPULSE, T_DSETUP) cycles, only while the select strobe is low. Select and write strobes rise together, and the output gate stays high for the whole write.
- R4: `mem_dq_oe` is high only from the first write-strobe cycle through T_HOLD cycles after the strobe rises, for W + T_HOLD cycles in all. The write data is driven for at least T_DSETUP cycles before the strobe ends, and the output gate is never low while the bus is driven.
- R5: `mem_addr` takes the request address at acceptance and keeps it unchanged until the controller is ready again.
- R6: `resp_valid` is a one-cycle pulse, once per request. For a write it comes T_ADDR_SETUP + W + T_HOLD cycles after acceptance, and `resp_err` is low on a completed access.
- R7: `req_ready` is low while a request is in progress. It returns T_RECOVER + 1 cycles after a read response and T_RECOVER cycles after a write response, so the strobes stay high at least T_RECOVER cycles between accesses.
- R8: A request accepted while `pwr_good` is low gets `resp_valid` with `resp_err` high in the cycle after acceptance. No strobe goes low and memory is unchanged. No access begins while `pwr_good` is low.
- R9: If `pwr_good` falls after a write is accepted, that write still completes with full pulse and hold, its data reaches memory, and it is answered without error.
- R10: If `pwr_good` falls during a read, the select and output-gate strobes go high in the same cycle. The read is answered with `resp_err` high one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Request refused or abandoned for power |
| resp_rdata | output | 8 | Captured read byte |
| pwr_good | input | 1 | Supply within tolerance |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data returned by memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
All counts are taken from the clock edge that accepts a request, with default parameters. A read response appears after 4 edges, and the controller is ready 3 edges later. A write response appears after 6 edges, and the controller is ready 2 edges later. A refused request is answered after the accepting edge itself. An abandoned read is answered one edge after the supply drops, and its strobes rise within that same cycle. Every request runs through one task that samples on falling clock edges and counts, cycle by cycle, the low strobe cycles, the bus-drive cycles, the response position and the ready position. Those counts are compared with latencies the bench derives from its own copy of the parameters.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_DONE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RECOVER
  } ctrl_state_t;

  // Write strobe length: long enough for both pulse width and data setup.
  function automatic int unsigned strobe_cycles(int unsigned wpulse, int unsigned dsetup);
    return (wpulse >= dsetup) ? wpulse : dsetup;
  endfunction

  // Phases of an accepted write; these are never cut short by power loss.
  function automatic logic in_write(ctrl_state_t s);
    return (s == ST_WR_SETUP) || (s == ST_WR_PULSE) || (s == ST_WR_HOLD);
  endfunction

  // Phases in which the memory is selected.
  function automatic logic wants_select(ctrl_state_t s);
    return (s == ST_RD_SETUP) || (s == ST_RD_WAIT) ||
           (s == ST_WR_SETUP) || (s == ST_WR_PULSE);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_strobe_decode.sv
`timescale 1ns/1ps
module sram_strobe_decode
  import sram_ctrl_pkg::*;
(
  input  ctrl_state_t state_i,
  input  logic        pwr_good_i,
  output logic        ce_n_o,
  output logic        oe_n_o,
  output logic        we_n_o,
  output logic        dq_oe_o
);
  // A write already accepted keeps its select; anything else drops on power loss.
  logic sel_allowed;
  assign sel_allowed = pwr_good_i || in_write(state_i);

  assign ce_n_o  = !(wants_select(state_i) && sel_allowed);
  assign oe_n_o  = !((state_i == ST_RD_WAIT) && pwr_good_i);
  assign we_n_o  = !(state_i == ST_WR_PULSE);
  assign dq_oe_o = (state_i == ST_WR_PULSE) || (state_i == ST_WR_HOLD);
endmodule

// File: rtl/sram_xfer_regs.sv
`timescale 1ns/1ps
module sram_xfer_regs #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              resp_set_i,
  input  logic              err_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              resp_valid_o,
  output logic              resp_err_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o       <= '0;
      wdata_o      <= '0;
      rdata_o      <= '0;
      resp_valid_o <= 1'b0;
      resp_err_o   <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (capture_i) rdata_o <= rdata_i;
      resp_valid_o <= resp_set_i;
      resp_err_o   <= resp_set_i && err_i;
    end
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 8,
  parameter int T_ADDR_SETUP = 1,
  parameter int T_ACCESS     = 3,
  parameter int T_WPULSE     = 2,
  parameter int T_DSETUP     = 3,
  parameter int T_HOLD       = 2,
  parameter int T_RECOVER    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              pwr_good,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int STROBE_LEN = int'(strobe_cycles(T_WPULSE, T_DSETUP));

  ctrl_state_t st_q, st_nxt;

  // Named internal events, visible to the checker and to waveforms.
  logic accept_w, capture_w, wr_done_w, err_ev_w, resp_set_w, load_w, expired_w;
  logic [CNT_W-1:0] load_val_w;

  // Cycle count minus one for the phase being entered.
  function automatic logic [CNT_W-1:0] phase_load(ctrl_state_t s);
    case (s)
      ST_RD_SETUP, ST_WR_SETUP: return CNT_W'(T_ADDR_SETUP - 1);
      ST_RD_WAIT:               return CNT_W'(T_ACCESS - 1);
      ST_WR_PULSE:              return CNT_W'(STROBE_LEN - 1);
      ST_WR_HOLD:               return CNT_W'(T_HOLD - 1);
      ST_RECOVER:               return CNT_W'(T_RECOVER - 1);
      default:                  return '0;
    endcase
  endfunction

  always_comb begin
    st_nxt    = st_q;
    accept_w  = 1'b0;
    capture_w = 1'b0;
    wr_done_w = 1'b0;
    err_ev_w  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept_w = 1'b1;
          if (!pwr_good) begin
            st_nxt   = ST_RD_DONE;
            err_ev_w = 1'b1;
          end else if (req_write) begin
            st_nxt = ST_WR_SETUP;
          end else begin
            st_nxt = ST_RD_SETUP;
          end
        end
      end
      ST_RD_SETUP: begin
        if (!pwr_good) begin
          st_nxt   = ST_RD_DONE;
          err_ev_w = 1'b1;
        end else if (expired_w) begin
          st_nxt = ST_RD_WAIT;
        end
      end
      ST_RD_WAIT: begin
        if (!pwr_good) begin
          st_nxt   = ST_RD_DONE;
          err_ev_w = 1'b1;
        end else if (expired_w) begin
          st_nxt    = ST_RD_DONE;
          capture_w = 1'b1;
        end
      end
      ST_RD_DONE:  st_nxt = ST_RECOVER;
      ST_WR_SETUP: if (expired_w) st_nxt = ST_WR_PULSE;
      ST_WR_PULSE: if (expired_w) st_nxt = ST_WR_HOLD;
      ST_WR_HOLD: begin
        if (expired_w) begin
          st_nxt    = ST_RECOVER;
          wr_done_w = 1'b1;
        end
      end
      ST_RECOVER:  if (expired_w) st_nxt = ST_IDLE;
      default:     st_nxt = ST_IDLE;
    endcase
  end

  assign load_w     = (st_nxt != st_q);
  assign load_val_w = phase_load(st_nxt);
  assign resp_set_w = ((st_nxt == ST_RD_DONE) && (st_q != ST_RD_DONE)) || wr_done_w;
  assign req_ready  = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nxt;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .expired_o  (expired_w)
  );

  sram_strobe_decode u_strobe (
    .state_i    (st_q),
    .pwr_good_i (pwr_good),
    .ce_n_o     (mem_ce_n),
    .oe_n_o     (mem_oe_n),
    .we_n_o     (mem_we_n),
    .dq_oe_o    (mem_dq_oe)
  );

  sram_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept_w),
    .addr_i       (req_addr),
    .wdata_i      (req_wdata),
    .capture_i    (capture_w),
    .rdata_i      (mem_dq_in),
    .resp_set_i   (resp_set_w),
    .err_i        (err_ev_w),
    .addr_o       (mem_addr),
    .wdata_o      (mem_dq_out),
    .rdata_o      (resp_rdata),
    .resp_valid_o (resp_valid),
    .resp_err_o   (resp_err)
  );
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
`timescale 1ns/1ps
module sram_bus_ctrl_chk #(
  parameter int ADDR_W    = 17,
  parameter int T_DSETUP  = 3,
  parameter int T_HOLD    = 2,
  parameter int T_RECOVER = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_err,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [15:0] ce_high_run, drive_run, hold_run;

  // Run-length counters replace long $past windows.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_high_run <= 16'(T_RECOVER);
      drive_run   <= '0;
      hold_run    <= '0;
    end else begin
      if (!mem_ce_n)                    ce_high_run <= '0;
      else if (ce_high_run != 16'hFFFF) ce_high_run <= ce_high_run + 1'b1;
      drive_run <= (mem_dq_oe && !mem_we_n) ? drive_run + 1'b1 : '0;
      hold_run  <= (mem_dq_oe &&  mem_we_n) ? hold_run  + 1'b1 : '0;
    end
  end

  p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  p_no_bus_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_data_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (drive_run >= 16'(T_DSETUP)));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (hold_run >= 16'(T_HOLD)));

  p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe || !mem_we_n) |-> $stable(mem_addr));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_err_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_valid);

  p_recover_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (ce_high_run >= 16'(T_RECOVER)));

  p_deselect_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && req_ready) |-> (mem_ce_n && mem_we_n));

  p_no_start_unpowered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> pwr_good);

  p_read_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && mem_we_n && !mem_dq_oe) |-> mem_oe_n);
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .T_DSETUP  (T_DSETUP),
  .T_HOLD    (T_HOLD),
  .T_RECOVER (T_RECOVER)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_err   (resp_err),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr)
);

// File: tb/sram_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb;
  localparam int AS  = 1;
  localparam int ACC = 3;
  localparam int WPL = 2;
  localparam int DSU = 3;
  localparam int HLD = 2;
  localparam int REC = 2;
  // Expected figures, derived here from the requirements.
  localparam int W      = (WPL > DSU) ? WPL : DSU;
  localparam int RD_LAT = AS + ACC;
  localparam int WR_LAT = AS + W + HLD;
  localparam int RD_RDY = RD_LAT + 1 + REC;
  localparam int WR_RDY = WR_LAT + REC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic pwr_good = 1'b1;
  logic req_ready, resp_valid, resp_err, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  resp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  always #10 clk = ~clk;

  sram_bus_ctrl #(.T_ADDR_SETUP(AS), .T_ACCESS(ACC), .T_WPULSE(WPL),
                  .T_DSETUP(DSU), .T_HOLD(HLD), .T_RECOVER(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .pwr_good(pwr_good), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  // Small memory model keyed on the low address byte.
  logic [7:0] mem [0:255];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      mem[mem_addr[7:0]] <= mem_dq_out;
    end
  end
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 8'hEE;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  int g_lat, g_rdy, g_we, g_oe, g_ce, g_dq, g_conf, g_addr_bad, g_pulses, g_busy_rdy;
  int g_ce_drop, g_oe_drop, g_err;
  logic [7:0] g_rd;

  // Issue one request and record what the ports do until ready returns.
  task automatic issue(input logic wr, input logic [16:0] a, input logic [7:0] d,
                       input int drop_k);
    @(negedge clk);
    chk("R7", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    g_lat = -1; g_rdy = -1; g_we = 0; g_oe = 0; g_ce = 0; g_dq = 0; g_conf = 0;
    g_addr_bad = 0; g_pulses = 0; g_ce_drop = -1; g_oe_drop = -1; g_err = -1;
    g_rd = 8'h00; g_busy_rdy = -1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        g_busy_rdy = int'(req_ready);
      end
      if (req_ready) begin
        g_rdy = k;
        break;
      end
      if (!mem_we_n) g_we++;
      if (!mem_oe_n) g_oe++;
      if (!mem_ce_n) g_ce++;
      if (mem_dq_oe) g_dq++;
      if (!mem_oe_n && (!mem_we_n || mem_dq_oe)) g_conf++;
      if (mem_addr != a) g_addr_bad++;
      if (resp_valid) begin
        g_pulses++;
        if (g_lat < 0) begin
          g_lat = k; g_err = int'(resp_err); g_rd = resp_rdata;
        end
      end
      if (k == drop_k) begin
        pwr_good = 1'b0;
        #1;
        g_ce_drop = int'(mem_ce_n);
        g_oe_drop = int'(mem_oe_n);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ce_n in reset", int'(mem_ce_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ce_n", int'(mem_ce_n), 1);
    chk("R1", "oe_n", int'(mem_oe_n), 1);
    chk("R1", "we_n", int'(mem_we_n), 1);
    chk("R1", "dq_oe", int'(mem_dq_oe), 0);
    chk("R1", "resp_valid", int'(resp_valid), 0);
    chk("R1", "req_ready", int'(req_ready), 1);
  endtask

  task automatic t_read(input logic [16:0] a, input logic [7:0] exp_d);
    issue(1'b0, a, 8'h00, -1);
    chk("R2", "read latency", g_lat, RD_LAT);
    chk("R2", "read data", int'(g_rd), int'(exp_d));
    chk("R2", "oe low cycles", g_oe, ACC);
    chk("R2", "ce low cycles", g_ce, AS + ACC);
    chk("R3", "we low during read", g_we, 0);
    chk("R6", "read err", g_err, 0);
    chk("R6", "read pulses", g_pulses, 1);
    chk("R5", "addr changes", g_addr_bad, 0);
    chk("R7", "busy ready", g_busy_rdy, 0);
    chk("R7", "read ready", g_rdy, RD_RDY);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    issue(1'b1, a, d, -1);
    chk("R3", "we low cycles", g_we, W);
    chk("R3", "ce low cycles", g_ce, AS + W);
    chk("R3", "oe low in write", g_oe, 0);
    chk("R4", "drive cycles", g_dq, W + HLD);
    chk("R4", "oe vs drive", g_conf, 0);
    chk("R5", "addr changes", g_addr_bad, 0);
    chk("R6", "write latency", g_lat, WR_LAT);
    chk("R6", "write err", g_err, 0);
    chk("R6", "write pulses", g_pulses, 1);
    chk("R7", "write ready", g_rdy, WR_RDY);
  endtask

  task automatic t_reject(input logic wr, input logic [16:0] a);
    pwr_good = 1'b0;
    issue(wr, a, 8'hC3, -1);
    chk("R8", "reject latency", g_lat, 0);
    chk("R8", "reject err", g_err, 1);
    chk("R8", "ce low cycles", g_ce, 0);
    chk("R8", "we low cycles", g_we, 0);
    chk("R8", "reject pulses", g_pulses, 1);
    pwr_good = 1'b1;
  endtask

  task automatic t_pf_write(input logic [16:0] a, input logic [7:0] d);
    issue(1'b1, a, d, 2);
    chk("R9", "we low cycles", g_we, W);
    chk("R9", "drive cycles", g_dq, W + HLD);
    chk("R9", "latency", g_lat, WR_LAT);
    chk("R9", "err", g_err, 0);
    issue(1'b1, a, ~d, -1);
    chk("R8", "queued write err", g_err, 1);
    chk("R8", "queued write we", g_we, 0);
    pwr_good = 1'b1;
    t_read(a, d);
  endtask

  task automatic t_pf_read(input logic [16:0] a);
    issue(1'b0, a, 8'h00, 2);
    chk("R10", "ce at drop", g_ce_drop, 1);
    chk("R10", "oe at drop", g_oe_drop, 1);
    chk("R10", "latency", g_lat, 3);
    chk("R10", "err", g_err, 1);
    pwr_good = 1'b1;
  endtask

  initial begin
    t_reset();
    t_read(17'h1_2345, 8'h45 ^ 8'h5A);
    t_read(17'h0_0000, 8'h00 ^ 8'h5A);
    t_write(17'h1_FFFF, 8'hA5);
    t_read(17'h1_FFFF, 8'hA5);
    t_write(17'h0_0010, 8'h3C);
    t_read(17'h0_0010, 8'h3C);
    t_reject(1'b1, 17'h0_0020);
    t_read(17'h0_0020, 8'h20 ^ 8'h5A);
    t_reject(1'b0, 17'h0_0021);
    t_pf_write(17'h0_0030, 8'h96);
    t_pf_read(17'h0_0040);
    t_read(17'h0_0040, 8'h40 ^ 8'h5A);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule